// File: doc/BRIEF.md
# Power-Up-Preset Modulo-8 Counter

This block is a modulo-8 counter built on top of a decimal counter. It does not start from zero. While the power-on pulse is high, the count is forced to nine. The first falling edge of the count clock after that pulse takes the count to zero. From then on, each falling edge adds one, through the values zero to seven.

The step after seven loads eight. A truncation decode (top bit high, bottom bit low) sees the eight and clears it to zero on the next system clock. The decode looks at the bottom bit so that the power-up value nine, which also has the top bit set, is never cleared.

The count clock is asynchronous to the system clock. It passes through a synchronizer and a falling-edge detector before it reaches a three-state controller:

- `ST_PRESET` holds nine.
- `ST_RUN` counts.
- `ST_TRUNC` lasts one system cycle and clears the eight.

The transitions are:

- Power-on pulse: any state goes to `ST_PRESET`.
- Falling edge in `ST_PRESET`: goes to `ST_RUN` and loads zero.
- Falling edge at seven in `ST_RUN`: goes to `ST_TRUNC` and loads eight.
- `ST_TRUNC`: always returns to `ST_RUN`, with the count cleared.

Top module: `pwrup_mod8_counter`

## Requirements
- R1: While `por_i` is high, `count_o` shows 9 (4'b1001) from the next system clock edge on, whatever the count clock does.
- R2: After the power-on pulse, the first falling edge of `cnt_clk_i` changes `count_o` from 9 to 0.
- R3: After that edge, each falling edge of `cnt_clk_i` raises `count_o` by one, through the values 0 to 7.
- R4: A falling edge at count 7 makes `count_o` show 8 (4'b1000) for exactly one system cycle. On the next system clock edge it shows 0.
- R5: With no falling edge of `cnt_clk_i`, the value 9 stays on `count_o` for any number of cycles. The truncation decode does not clear it.
- R6: Rising edges of `cnt_clk_i` leave `count_o` unchanged.
- R7: `count_o` changes on the third rising edge of `clk_i` after `cnt_clk_i` falls: two synchronizer stages, then the count register.
- R8: `count_o` only ever holds 0 to 9, and never shows 8 on two cycles in a row.
- R9: Raising `por_i` again in the middle of a count returns `count_o` to 9. The next falling edge after the pulse then gives 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock; every register updates on its rising edge |
| por_i | input | 1 | Power-on pulse, active high, synchronous; presets the count to 9 |
| cnt_clk_i | input | 1 | Count clock, asynchronous; the count advances on its falling edges |
| count_o | output | 4 | Current count |

## Verification
The bench builds the block with its defaults: a 4-bit count and a two-stage synchronizer. With a 4-bit count the modulus is eight, so the wrap through eight comes within nine count pulses. The two-stage synchronizer fixes the update at the third system edge, which the bench samples one cycle at a time around that edge. It also samples the count on the single cycle it shows eight, and checks that nine holds under long stretches of both count-clock levels.

// File: rtl/pwrup_mod8_pkg.sv
package pwrup_mod8_pkg;
    typedef enum logic [1:0] {
        ST_PRESET = 2'd0,
        ST_RUN    = 2'd1,
        ST_TRUNC  = 2'd2
    } phase_e;
endpackage

// File: rtl/pwrup_mod8_sync.sv
module pwrup_mod8_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk_i) chain_q[g] <= async_i;
            end else begin : g_next
                always_ff @(posedge clk_i) chain_q[g] <= chain_q[g-1];
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/pwrup_mod8_fall.sv
module pwrup_mod8_fall (
    input  logic clk_i,
    input  logic level_i,
    output logic fall_o
);
    logic last_q;

    always_ff @(posedge clk_i) last_q <= level_i;

    assign fall_o = last_q & ~level_i;
endmodule

// File: rtl/pwrup_mod8_ctrl.sv
module pwrup_mod8_ctrl
    import pwrup_mod8_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk_i,
    input  logic             por_i,
    input  logic             fall_i,
    output logic [CNT_W-1:0] count_o
);
    localparam logic [CNT_W-1:0] TRUNC_VAL  = CNT_W'(1) << (CNT_W - 1);
    localparam logic [CNT_W-1:0] LAST_VAL   = TRUNC_VAL - CNT_W'(1);
    localparam logic [CNT_W-1:0] PRESET_VAL = TRUNC_VAL | CNT_W'(1);

    phase_e           state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             trunc_hit;

    assign trunc_hit = cnt_q[CNT_W-1] & ~cnt_q[0];

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (por_i) begin
            state_d = ST_PRESET;
            cnt_d   = PRESET_VAL;
        end else begin
            unique case (state_q)
                ST_PRESET: begin
                    cnt_d = PRESET_VAL;
                    if (fall_i) begin
                        state_d = ST_RUN;
                        cnt_d   = '0;
                    end
                end
                ST_RUN: begin
                    if (fall_i) begin
                        cnt_d = cnt_q + CNT_W'(1);
                        if (cnt_q == LAST_VAL) state_d = ST_TRUNC;
                    end
                end
                ST_TRUNC: begin
                    state_d = ST_RUN;
                    if (trunc_hit) cnt_d = '0;
                end
                default: begin
                    state_d = ST_PRESET;
                    cnt_d   = PRESET_VAL;
                end
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        state_q <= state_d;
        cnt_q   <= cnt_d;
    end

    assign count_o = cnt_q;
endmodule

// File: rtl/pwrup_mod8_counter.sv
module pwrup_mod8_counter #(
    parameter int CNT_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_i,
    input  logic             por_i,
    input  logic             cnt_clk_i,
    output logic [CNT_W-1:0] count_o
);
    logic cnt_clk_sync;
    logic cnt_fall;

    pwrup_mod8_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i   (clk_i),
        .async_i (cnt_clk_i),
        .sync_o  (cnt_clk_sync)
    );

    pwrup_mod8_fall u_fall (
        .clk_i   (clk_i),
        .level_i (cnt_clk_sync),
        .fall_o  (cnt_fall)
    );

    pwrup_mod8_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk_i   (clk_i),
        .por_i   (por_i),
        .fall_i  (cnt_fall),
        .count_o (count_o)
    );
endmodule

// File: rtl/pwrup_mod8_counter_chk.sv
module pwrup_mod8_counter_chk #(
    parameter int CNT_W = 4
) (
    input logic             clk_i,
    input logic             por_i,
    input logic [CNT_W-1:0] count_o
);
    localparam logic [CNT_W-1:0] EIGHT = CNT_W'(1) << (CNT_W - 1);
    localparam logic [CNT_W-1:0] NINE  = EIGHT | CNT_W'(1);

    logic primed = 1'b0;
    always_ff @(posedge clk_i) primed <= primed | por_i;

    // R1
    por_hold_chk: assert property (@(posedge clk_i) disable iff (!primed)
        por_i |=> (count_o == NINE));

    // R2
    preset_exit_chk: assert property (@(posedge clk_i) disable iff (!primed)
        (!por_i && count_o == NINE) |=> (count_o == NINE || count_o == '0));

    // R3
    step_chk: assert property (@(posedge clk_i) disable iff (!primed)
        (!por_i && count_o < EIGHT)
        |=> (count_o == $past(count_o) || count_o == $past(count_o) + CNT_W'(1)));

    // R4
    trunc_clear_chk: assert property (@(posedge clk_i) disable iff (!primed)
        (!por_i && count_o == EIGHT) |=> (count_o == '0));

    // R8
    single_eight_chk: assert property (@(posedge clk_i) disable iff (!primed)
        (count_o == EIGHT) |=> (count_o != EIGHT));

    // R8
    range_chk: assert property (@(posedge clk_i) disable iff (!primed)
        $past(primed) |-> (count_o <= NINE));
endmodule

bind pwrup_mod8_counter pwrup_mod8_counter_chk #(.CNT_W(CNT_W)) u_chk (
    .clk_i   (clk_i),
    .por_i   (por_i),
    .count_o (count_o)
);

// File: tb/pwrup_mod8_counter_bench.sv
module pwrup_mod8_counter_bench;
    logic       clk = 1'b0;
    logic       por = 1'b0;
    logic       cnt_clk = 1'b1;
    logic [3:0] count;
    int         checks = 0;
    int         failures = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    pwrup_mod8_counter u_pwrup_mod8_counter (
        .clk_i     (clk),
        .por_i     (por),
        .cnt_clk_i (cnt_clk),
        .count_o   (count)
    );

    // {apply power-on pulse, expected count afterwards}
    localparam logic [4:0] VEC [0:12] = '{
        {1'b1, 4'd9}, {1'b0, 4'd0}, {1'b0, 4'd1}, {1'b0, 4'd2}, {1'b0, 4'd3},
        {1'b0, 4'd4}, {1'b0, 4'd5}, {1'b0, 4'd6}, {1'b0, 4'd7}, {1'b0, 4'd0},
        {1'b0, 4'd1}, {1'b1, 4'd9}, {1'b0, 4'd0}
    };

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s count actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic por_pulse();
        por = 1'b1;
        cyc(3);
        por = 1'b0;
        cyc(2);
    endtask

    task automatic count_pulse();
        cnt_clk = 1'b1;
        cyc(4);
        cnt_clk = 1'b0;
        cyc(5);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [3:0] prev_exp = 4'd9;
        cyc(2);
        // R1: reset state while the pulse is held, count clock toggling
        por = 1'b1;
        cyc(2);
        check("R1", count, 4'd9);
        cnt_clk = 1'b0;
        cyc(4);
        cnt_clk = 1'b1;
        cyc(4);
        check("R1", count, 4'd9);
        por = 1'b0;
        cyc(2);

        // table walk: R1 pulses, R2 first edge, R3 steps, R4 wrap
        for (int i = 0; i < 13; i++) begin
            if (VEC[i][4]) por_pulse(); else count_pulse();
            if (VEC[i][4])            check("R1", count, VEC[i][3:0]);
            else if (prev_exp == 4'd9) check("R2", count, VEC[i][3:0]);
            else if (VEC[i][3:0] == 4'd0) check("R4", count, VEC[i][3:0]);
            else                      check("R3", count, VEC[i][3:0]);
            prev_exp = VEC[i][3:0];
        end

        // R6: rising edge alone does nothing (count is 0 here, clock low)
        cnt_clk = 1'b1;
        cyc(6);
        check("R6", count, 4'd0);

        // R7: update lands on the third rising edge after the fall
        cnt_clk = 1'b0;
        cyc(2);
        check("R7", count, 4'd0);
        cyc(1);
        check("R7", count, 4'd1);
        cyc(2);

        // advance to 7, then R4/R8: eight shown for one cycle only
        for (int k = 0; k < 6; k++) count_pulse();
        check("R3", count, 4'd7);
        cnt_clk = 1'b1;
        cyc(4);
        cnt_clk = 1'b0;
        cyc(3);
        check("R4", count, 4'd8);
        cyc(1);
        check("R8", count, 4'd0);
        cyc(2);

        // R9: pulse mid count, then first edge gives 0
        count_pulse();
        count_pulse();
        check("R3", count, 4'd2);
        por_pulse();
        check("R9", count, 4'd9);
        count_pulse();
        check("R9", count, 4'd0);

        // R5: nine survives long stretches at both clock levels
        por_pulse();
        cnt_clk = 1'b1;
        cyc(40);
        check("R5", count, 4'd9);
        por = 1'b1;
        cnt_clk = 1'b0;
        cyc(3);
        por = 1'b0;
        cyc(40);
        check("R5", count, 4'd9);
        cnt_clk = 1'b1;
        cyc(6);
        check("R6", count, 4'd9);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule